// File: doc/BRIEF.md
# Accumulator Processor Core with Selectable Operand Addressing

This block is a compact accumulator processor. It steps through a fixed register-transfer sequence for every instruction. A program counter feeds a memory address register. The returned word is captured in an instruction register and then executed against an accumulator `A` and a signed index register `X`. Every instruction word carries its own addressing-mode field. The sequencer and the address generator use that field to choose how the operand is found:

- **direct:** the field is the address.
- **immediate:** the field itself is the value.
- **relative:** the field is a signed offset from the instruction's own address.
- **indexed:** the field plus `X`.

The core talks to an external synchronous single-port memory with one cycle of read latency. The memory returns the word at `mem_addr` on the clock edge after that address is presented. The core writes `A` to memory when `mem_we` is high. Results leave the core through an output bus with a one-cycle valid strobe. A halt instruction parks the core until reset.

The sequencer states are:

| State | Action | Next state |
|---|---|---|
| FETCH | copy PC into the address register | IWAIT |
| IWAIT | memory access cycle | DECODE |
| DECODE | capture the instruction word | EXEC |
| EXEC | carry out the instruction | see below |
| OWAIT | operand access cycle | OPER |
| OPER | use the operand from memory | FETCH |
| STORE | write pulse | FETCH |
| HALT | park until reset | HALT |

Leaving EXEC, the sequencer goes:

- to HALT on the halt opcode;
- to STORE on a store;
- to OWAIT on a load, add or load-index whose mode is not immediate;
- to FETCH for everything else.

Top module: `accum_cpu`

## Requirements
- R1: After reset the program counter, `A` and `X` are zero, `out_valid`, `mem_we` and `halted` are low, and the first instruction is fetched from address 0.
- R2: An instruction word is {opcode[15:12], mode[11:10], field[9:0]}. Opcodes: 0 halt, 1 load A, 2 add to A, 3 store A, 4 load X, 5 decrement X, 6 branch if X non-negative, 7 output A. Modes: 0 direct, 1 immediate, 2 relative, 3 indexed. Each instruction first copies PC to the address register, then loads the returned word into the instruction register.
- R3: In direct mode the operand of load A, add and load X is the memory word at the address given by the field.
- R4: In immediate mode, load A, add and load X use the zero-extended field as the operand and make no operand memory access. Store and branch in immediate mode treat the field as a direct address.
- R5: In relative mode the effective address is the instruction's own address plus the field read as a signed 10-bit value, modulo 1024, so backward offsets work.
- R6: In indexed mode the effective address is the field plus the low 10 bits of `X`, modulo 1024.
- R7: A store writes `A` to the effective address with a single write pulse; a later load from that address returns it.
- R8: Decrement X subtracts one from `X`. The branch loads PC with the effective address when `X` bit 15 is 0, otherwise PC advances by one, so a count-down loop ends when `X` passes from 0 to -1.
- R9: Output A drives `A` on `out_data` with `out_valid` high for exactly one cycle.
- R10: Halt raises `halted` permanently. PC, and with it `mem_addr`, stop changing, and no further writes or outputs occur.
- R11: Opcodes 8 to 15 change neither `A` nor `X` and only advance PC.
- R12: Instructions without an operand access take 4 cycles, operand loads take 6 and stores take 5, so back-to-back outputs are 4 cycles apart and an output after a direct add is 10 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 10 | Memory address, driven by the address register |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| out_data | output | 16 | Output bus |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A wrong effective address or a wrong accumulator update cannot be seen directly. It shows up only at the next output instruction, as a wrong `out_data` value, or after halt, as a wrong word in memory. Programs therefore place an output right after each mode under test. An index loop that branches one time too many or too few changes the accumulated sum, and shifts every later output by a multiple of the loop length in cycles. Sequencer faults show up within a few cycles as changed spacing between output strobes. A missed halt shows up as extra outputs or a moving `mem_addr`.

// File: rtl/acpu_pkg.sv
package acpu_pkg;

    localparam int OP_W   = 4;
    localparam int MODE_W = 2;

    typedef enum logic [3:0] {
        OP_HALT = 4'd0,
        OP_LDA  = 4'd1,
        OP_ADD  = 4'd2,
        OP_STA  = 4'd3,
        OP_LDX  = 4'd4,
        OP_DECX = 4'd5,
        OP_BRPX = 4'd6,
        OP_OUT  = 4'd7
    } opcode_e;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,
        AM_IMM    = 2'd1,
        AM_REL    = 2'd2,
        AM_INDEX  = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_IWAIT,
        S_DECODE,
        S_EXEC,
        S_OWAIT,
        S_OPER,
        S_STORE,
        S_HALT
    } state_e;

    // True for opcodes that read an operand word from memory in this mode
    function automatic logic needs_operand(input logic [OP_W-1:0] op,
                                           input logic [MODE_W-1:0] md);
        logic reads;
        reads = (op == OP_LDA) || (op == OP_ADD) || (op == OP_LDX);
        return reads && (md != AM_IMM);
    endfunction

endpackage

// File: rtl/acpu_seq.sv
module acpu_seq
    import acpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op,
    input  logic [MODE_W-1:0] mode,
    output logic              mar_from_pc,
    output logic              ir_load,
    output logic              exec_step,
    output logic              oper_step,
    output logic              store_step,
    output logic              mem_we,
    output logic              halted
);

    state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:  state_d = S_IWAIT;
            S_IWAIT:  state_d = S_DECODE;
            S_DECODE: state_d = S_EXEC;
            S_EXEC: begin
                if (op == OP_HALT)               state_d = S_HALT;
                else if (op == OP_STA)           state_d = S_STORE;
                else if (needs_operand(op, mode)) state_d = S_OWAIT;
                else                             state_d = S_FETCH;
            end
            S_OWAIT:  state_d = S_OPER;
            S_OPER:   state_d = S_FETCH;
            S_STORE:  state_d = S_FETCH;
            S_HALT:   state_d = S_HALT;
            default:  state_d = S_FETCH;
        endcase
    end

    // Outputs
    always_comb begin
        mar_from_pc = 1'b0;
        ir_load     = 1'b0;
        exec_step   = 1'b0;
        oper_step   = 1'b0;
        store_step  = 1'b0;
        mem_we      = 1'b0;
        halted      = 1'b0;
        unique case (state_q)
            S_FETCH:  mar_from_pc = 1'b1;
            S_IWAIT:  ;
            S_DECODE: ir_load = 1'b1;
            S_EXEC:   exec_step = 1'b1;
            S_OWAIT:  ;
            S_OPER:   oper_step = 1'b1;
            S_STORE: begin
                store_step = 1'b1;
                mem_we     = 1'b1;
            end
            S_HALT:   halted = 1'b1;
            default:  ;
        endcase
    end

    // R2: at most one datapath step per cycle
    assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mar_from_pc, ir_load, exec_step, oper_step, store_step}));

    // R2: the instruction register is loaded only after the memory wait cycle
    assert_ir_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> $past(state_q) == S_IWAIT);

    // R10: halt is permanent and silent on the memory bus
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

endmodule

// File: rtl/acpu_agen.sv
module acpu_agen
    import acpu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] x_low,
    output logic [ADDR_W-1:0] ea
);

    // Modulo-2^ADDR_W sums: a signed offset adds exactly like an unsigned one
    always_comb begin
        unique case (mode)
            AM_REL:   ea = pc + field;
            AM_INDEX: ea = field + x_low;
            default:  ea = field;
        endcase
    end

endmodule

// File: rtl/acpu_dpath.sv
module acpu_dpath
    import acpu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mar_from_pc,
    input  logic              ir_load,
    input  logic              exec_step,
    input  logic              oper_step,
    input  logic              store_step,
    input  logic              halted,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] ea,
    output logic [OP_W-1:0]   op,
    output logic [MODE_W-1:0] mode,
    output logic [ADDR_W-1:0] field,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] xreg,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    localparam int XMSB = DATA_W - 1;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, a_q, x_q, out_q;
    logic              outv_q;
    logic [DATA_W-1:0] imm_val;
    logic [ADDR_W-1:0] pc_next;
    logic              is_imm;

    assign op      = ir_q[DATA_W-1 -: OP_W];
    assign mode    = ir_q[ADDR_W +: MODE_W];
    assign field   = ir_q[ADDR_W-1:0];
    assign imm_val = {{(DATA_W-ADDR_W){1'b0}}, field};
    assign pc_next = pc_q + 1'b1;
    assign is_imm  = (mode == AM_IMM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mar_q  <= '0;
            ir_q   <= '0;
            a_q    <= '0;
            x_q    <= '0;
            out_q  <= '0;
            outv_q <= 1'b0;
        end else begin
            outv_q <= 1'b0;
            if (mar_from_pc) mar_q <= pc_q;
            if (ir_load)     ir_q  <= mem_rdata;
            if (exec_step) begin
                unique case (op)
                    OP_HALT: ;
                    OP_LDA: begin
                        if (is_imm) begin
                            a_q  <= imm_val;
                            pc_q <= pc_next;
                        end else begin
                            mar_q <= ea;
                        end
                    end
                    OP_ADD: begin
                        if (is_imm) begin
                            a_q  <= a_q + imm_val;
                            pc_q <= pc_next;
                        end else begin
                            mar_q <= ea;
                        end
                    end
                    OP_LDX: begin
                        if (is_imm) begin
                            x_q  <= imm_val;
                            pc_q <= pc_next;
                        end else begin
                            mar_q <= ea;
                        end
                    end
                    OP_STA:  mar_q <= ea;
                    OP_DECX: begin
                        x_q  <= x_q - 1'b1;
                        pc_q <= pc_next;
                    end
                    OP_BRPX: pc_q <= x_q[XMSB] ? pc_next : ea;
                    OP_OUT: begin
                        out_q  <= a_q;
                        outv_q <= 1'b1;
                        pc_q   <= pc_next;
                    end
                    default: pc_q <= pc_next;
                endcase
            end
            if (oper_step) begin
                unique case (op)
                    OP_LDA:  a_q <= mem_rdata;
                    OP_ADD:  a_q <= a_q + mem_rdata;
                    OP_LDX:  x_q <= mem_rdata;
                    default: ;
                endcase
                pc_q <= pc_next;
            end
            if (store_step) pc_q <= pc_next;
        end
    end

    assign pc        = pc_q;
    assign mar       = mar_q;
    assign acc       = a_q;
    assign xreg      = x_q;
    assign out_data  = out_q;
    assign out_valid = outv_q;

    // R2: the fetch step points memory at the current PC
    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mar_from_pc |=> mar_q == $past(pc_q));

    // R4: immediate operands never move the address register
    assert_imm_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_step && is_imm && (op == OP_LDA || op == OP_ADD || op == OP_LDX))
        |=> $stable(mar_q));

    // R8: decrement and branch
    assert_dec_x_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_step && op == OP_DECX) |=> x_q == DATA_W'($past(x_q) - 1'b1));

    assert_branch_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_step && op == OP_BRPX && !x_q[XMSB]) |=> pc_q == $past(ea));

    assert_branch_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_step && op == OP_BRPX && x_q[XMSB])
        |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

    // R9: output strobe lasts one cycle
    assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        outv_q |=> !outv_q);

    // R10: PC frozen once halted
    assert_pc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_q));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
    import acpu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            mem_we,
    output logic [OP_W+MODE_W+ADDR_W-1:0]   mem_wdata,
    input  logic [OP_W+MODE_W+ADDR_W-1:0]   mem_rdata,
    output logic [OP_W+MODE_W+ADDR_W-1:0]   out_data,
    output logic                            out_valid,
    output logic                            halted
);

    localparam int DATA_W = OP_W + MODE_W + ADDR_W;

    logic              mar_from_pc, ir_load, exec_step, oper_step, store_step;
    logic [OP_W-1:0]   op;
    logic [MODE_W-1:0] mode;
    logic [ADDR_W-1:0] field, pc, mar, ea;
    logic [DATA_W-1:0] acc, xreg;

    acpu_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .mode        (mode),
        .mar_from_pc (mar_from_pc),
        .ir_load     (ir_load),
        .exec_step   (exec_step),
        .oper_step   (oper_step),
        .store_step  (store_step),
        .mem_we      (mem_we),
        .halted      (halted)
    );

    acpu_agen #(.ADDR_W(ADDR_W)) u_agen (
        .mode  (mode),
        .field (field),
        .pc    (pc),
        .x_low (xreg[ADDR_W-1:0]),
        .ea    (ea)
    );

    acpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .mar_from_pc (mar_from_pc),
        .ir_load     (ir_load),
        .exec_step   (exec_step),
        .oper_step   (oper_step),
        .store_step  (store_step),
        .halted      (halted),
        .mem_rdata   (mem_rdata),
        .ea          (ea),
        .op          (op),
        .mode        (mode),
        .field       (field),
        .pc          (pc),
        .mar         (mar),
        .acc         (acc),
        .xreg        (xreg),
        .out_data    (out_data),
        .out_valid   (out_valid)
    );

    assign mem_addr  = mar;
    assign mem_wdata = acc;

    // R10: no output strobe while parked
    assert_halt_no_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !out_valid);

endmodule

// File: tb/accum_cpu_tb.sv
`timescale 1ns/1ps
module accum_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata, mem_rdata, out_data;
    logic        out_valid, halted;

    always #4 clk = ~clk;

    accum_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_data(out_data),
        .out_valid(out_valid), .halted(halted)
    );

    logic [15:0] mem [1024];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          stamp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int md, input int fld);
        return {op[3:0], md[1:0], fld[9:0]};
    endfunction

    task automatic expect_out(input int val, input string req);
        exp_q.push_back(val[15:0]);
        tag_q.push_back(req);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            stamp_q.push_back(cyc);
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected output", out_data, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data == e, t, "out_data", out_data, e);
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    endtask

    task automatic run_until_halt(input string req);
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (!halted && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(halted == 1'b1, req, "halted reached", halted, 1);
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] parked;

        // ---------- program 1: direct, immediate, store, undefined, timing
        rst_n = 1'b0;
        clear_mem();
        mem[0]   = enc(1, 1, 5);      // LDA #5
        mem[1]   = enc(7, 0, 0);      // OUT 5
        mem[2]   = enc(2, 0, 100);    // ADD 100 -> 12
        mem[3]   = enc(7, 0, 0);      // OUT 12
        mem[4]   = enc(3, 0, 101);    // STA 101
        mem[5]   = enc(1, 1, 1);      // LDA #1
        mem[6]   = enc(1, 0, 101);    // LDA 101 -> 12
        mem[7]   = enc(7, 0, 0);      // OUT 12
        mem[8]   = 16'h9000;          // undefined opcode 9
        mem[9]   = enc(7, 0, 0);      // OUT 12
        mem[10]  = enc(7, 0, 0);      // OUT 12
        mem[11]  = enc(2, 1, 1023);   // ADD #1023 -> 1035
        mem[12]  = enc(7, 0, 0);      // OUT 1035
        mem[13]  = enc(3, 1, 102);    // STA in immediate mode -> mem[102]
        mem[14]  = enc(0, 0, 0);      // HALT
        mem[100] = 16'd7;

        repeat (2) @(negedge clk);
        // R1 reset state
        check(halted == 1'b0, "R1", "halted in reset", halted, 0);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        check(mem_addr == 10'd0, "R1", "mem_addr in reset", mem_addr, 0);

        expect_out(5, "R4");
        expect_out(12, "R3");
        expect_out(12, "R7");
        expect_out(12, "R11");
        expect_out(12, "R11");
        expect_out(1035, "R4");
        stamp_q.delete();
        run_until_halt("R10");

        parked = mem_addr;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9", "outputs outstanding", exp_q.size(), 0);
        check(halted == 1'b1, "R10", "halted stays high", halted, 1);
        check(mem_addr == parked, "R10", "mem_addr frozen", mem_addr, parked);
        check(mem[101] == 16'd12, "R7", "stored word", mem[101], 12);
        check(mem[102] == 16'd1035, "R4", "immediate-mode store", mem[102], 1035);
        if (stamp_q.size() == 6) begin
            check(stamp_q[1] - stamp_q[0] == 10, "R12", "gap across direct add",
                  stamp_q[1] - stamp_q[0], 10);
            check(stamp_q[4] - stamp_q[3] == 4, "R12", "back-to-back output gap",
                  stamp_q[4] - stamp_q[3], 4);
        end else begin
            check(1'b0, "R12", "output count", stamp_q.size(), 6);
        end

        // ---------- program 2: relative, indexed loop, branch, index wrap
        rst_n = 1'b0;
        @(negedge clk);
        clear_mem();
        mem[0]    = enc(1, 2, 50);    // LDA rel +50 -> 33
        mem[1]    = enc(7, 0, 0);     // OUT 33
        mem[2]    = enc(2, 2, 1022);  // ADD rel -2 -> + mem[0]
        mem[3]    = enc(7, 0, 0);     // OUT
        mem[4]    = enc(1, 1, 0);     // LDA #0
        mem[5]    = enc(4, 0, 60);    // LDX 60 -> 3
        mem[6]    = enc(2, 3, 200);   // ADD @200
        mem[7]    = enc(5, 0, 0);     // DECX
        mem[8]    = enc(6, 0, 6);     // BRPX 6
        mem[9]    = enc(7, 0, 0);     // OUT 100
        mem[10]   = enc(1, 3, 0);     // LDA @0 with X=-1 -> mem[1023]
        mem[11]   = enc(7, 0, 0);     // OUT 77
        mem[12]   = enc(0, 0, 0);     // HALT
        mem[50]   = 16'd33;
        mem[60]   = 16'd3;
        mem[200]  = 16'd10;
        mem[201]  = 16'd20;
        mem[202]  = 16'd30;
        mem[203]  = 16'd40;
        mem[1023] = 16'd77;

        expect_out(33, "R5");
        expect_out(33 + 32'(enc(1, 2, 50)), "R5");
        expect_out(100, "R8");
        expect_out(77, "R6");
        run_until_halt("R10");
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6", "outputs outstanding", exp_q.size(), 0);
        check(halted == 1'b1, "R10", "halted stays high", halted, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule